// File: doc/BRIEF.md
# Hardware Register Stack with Logical Stack Operations

This block is a last-in first-out store of 64 words of 8 bits, kept in registers and addressed by a 6-bit pointer. Each accepted command is one of these: a push, a pop, or a two-operand logical operation (OR, AND or XOR). A push moves the pointer up by one and then stores the input word at the new pointer location. A pop copies the word at the pointer into the output data register and then moves the pointer down by one. The pointer wraps around in 6 bits. The flags that show a full or an empty stack are therefore set by looking at the pointer value after each move.

A logical operation takes the two top words off the stack, combines them, and puts the result back on the stack. It does this in a fixed order over successive cycles: first pop, second pop, compute, push. A busy output stays high while this runs. Commands that cannot be carried out are refused. A refused command leaves the stack unchanged and raises a one-cycle error pulse. Commands are refused when they would overflow or underflow the stack, when they are logical operations on fewer than two words, when they arrive while the block is busy, or when they carry an undefined code.

Top module: `rstk_top`

## Requirements
- R1: Reset state. While reset is asserted, and in the first cycle after it, the outputs are: `stk_ptr` 0, `empty` 1, `full` 0, `busy` 0 and `err` 0.
- R2: Push. A valid push (`cmd_op` = 3'b001) on a stack that is not full is handled at the clock edge that samples it. At that edge `stk_ptr` goes up by one, `push_data` is stored at the new pointer location, and `empty` is cleared.
- R3: Pop. A valid pop (`cmd_op` = 3'b010) on a stack that is not empty loads `pop_data` with the word pushed most recently and not yet removed. `stk_ptr` goes down by one and `full` is cleared. `empty` becomes 1 when the pointer reaches 0.
- R4: Full. The push that brings the pointer from 63 back to 0 sets `full`. The stack then holds 64 words, and `full` and `empty` are never 1 together.
- R5: A push while `full` is 1 is refused. `err` is 1 for exactly the next cycle, `stk_ptr` and the flags keep their values, and the stored words are left as they were.
- R6: A pop while `empty` is 1 is refused. `err` pulses, and `stk_ptr`, the flags and `pop_data` keep their values.
- R7: Logical operations use these codes: OR is 3'b011, AND is 3'b100 and XOR is 3'b101. Each one replaces the two top words with the result of combining them bit by bit. The stack then holds one word fewer, and the words below the top two are left as they were.
- R8: A logical operation on a stack that holds fewer than two words is refused. `err` pulses, `busy` stays 0, and the pointer and flags do not change.
- R9: An accepted logical operation holds `busy` at 1 for exactly three cycles after the edge that accepts it. Any valid command that arrives while `busy` is 1 is refused with an `err` pulse and has no effect on the stack.
- R10: The codes 3'b000, 3'b110 and 3'b111 are undefined. A valid command with one of them is refused with an `err` pulse and causes no change. When `cmd_valid` is 0, the block ignores `cmd_op`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Marks the cycle in which `cmd_op` holds a command |
| cmd_op | input | 3 | Command code (see R2, R3, R7, R10) |
| push_data | input | 8 | Word that a push stores |
| pop_data | output | 8 | Output data register, loaded by each accepted pop |
| stk_ptr | output | 6 | Current stack pointer |
| full | output | 1 | The stack holds 64 words |
| empty | output | 1 | The stack holds no words |
| busy | output | 1 | A logical operation is running |
| err | output | 1 | One-cycle pulse after each refused command |

## Verification
The stack is filled with 64 distinct words, which drives the pointer through every value and checks the wrap that sets `full`. It is then drained. Because every word is different, the drain shows that the order is last-in first-out and that no location was overwritten. Each logical operation is run on a 16 by 16 grid of operand pairs. The grid contains pairs with disjoint bits, overlapping bits and equal bits, so OR, AND and XOR each give a different expected value and a wrong operation selection is exposed. Refused commands are placed at the boundaries: on an empty stack, with a single word, at full, during the busy window, and with each undefined code. After each one, the contents are read back by popping.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

    localparam logic [2:0] CMD_PUSH = 3'b001;
    localparam logic [2:0] CMD_POP  = 3'b010;
    localparam logic [2:0] CMD_OR   = 3'b011;
    localparam logic [2:0] CMD_AND  = 3'b100;
    localparam logic [2:0] CMD_XOR  = 3'b101;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_POP2 = 2'd1,
        SEQ_CALC = 2'd2,
        SEQ_PUSH = 2'd3
    } seq_e;

    typedef enum logic [1:0] {
        LOP_OR  = 2'd0,
        LOP_AND = 2'd1,
        LOP_XOR = 2'd2
    } lop_e;

endpackage

// File: rtl/rstk_regfile.sv
module rstk_regfile #(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << PTR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/rstk_ptr.sv
module rstk_ptr #(
    parameter int PTR_W = 6
) (
    input  logic [PTR_W-1:0] sp,
    input  logic             full,
    input  logic             empty,
    output logic [PTR_W-1:0] sp_up,
    output logic [PTR_W-1:0] sp_dn,
    output logic             wrap_up,
    output logic             zero_dn,
    output logic             can_push,
    output logic             can_pop,
    output logic             has_two
);
    localparam logic [PTR_W-1:0] ONE  = PTR_W'(1);
    localparam logic [PTR_W-1:0] TWO  = PTR_W'(2);
    localparam logic [PTR_W-1:0] ZERO = '0;

    assign sp_up    = sp + ONE;
    assign sp_dn    = sp - ONE;
    assign wrap_up  = (sp_up == ZERO);
    assign zero_dn  = (sp_dn == ZERO);
    assign can_push = ~full;
    assign can_pop  = ~empty;
    assign has_two  = full | (~empty & (sp >= TWO));

endmodule

// File: rtl/rstk_alu.sv
module rstk_alu
    import rstk_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  lop_e              sel,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign y[i] = (sel == LOP_AND) ? (a[i] & b[i]) :
                      (sel == LOP_XOR) ? (a[i] ^ b[i]) :
                                         (a[i] | b[i]);
    end

endmodule

// File: rtl/rstk_top.sv
module rstk_top
    import rstk_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [DATA_W-1:0] push_data,
    output logic [DATA_W-1:0] pop_data,
    output logic [PTR_W-1:0]  stk_ptr,
    output logic              full,
    output logic              empty,
    output logic              busy,
    output logic              err
);
    typedef struct packed {
        logic [PTR_W-1:0]  sp;
        logic              full;
        logic              empty;
        logic [DATA_W-1:0] dr;
        logic [DATA_W-1:0] opa;
        logic [DATA_W-1:0] opb;
        logic [DATA_W-1:0] res;
        lop_e              op;
        seq_e              st;
        logic              err;
    } state_t;

    localparam state_t RST_VAL = '{
        sp:    '0,
        full:  1'b0,
        empty: 1'b1,
        dr:    '0,
        opa:   '0,
        opb:   '0,
        res:   '0,
        op:    LOP_OR,
        st:    SEQ_IDLE,
        err:   1'b0
    };

    state_t state_q, state_d;

    logic [PTR_W-1:0]  sp_up, sp_dn;
    logic              wrap_up, zero_dn, can_push, can_pop, has_two;
    logic [DATA_W-1:0] rd_word, alu_y, wr_word;
    logic              wr_en;

    rstk_ptr #(.PTR_W(PTR_W)) u_ptr (
        .sp       (state_q.sp),
        .full     (state_q.full),
        .empty    (state_q.empty),
        .sp_up    (sp_up),
        .sp_dn    (sp_dn),
        .wrap_up  (wrap_up),
        .zero_dn  (zero_dn),
        .can_push (can_push),
        .can_pop  (can_pop),
        .has_two  (has_two)
    );

    rstk_regfile #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_mem (
        .clk   (clk),
        .we    (wr_en),
        .waddr (sp_up),
        .wdata (wr_word),
        .raddr (state_q.sp),
        .rdata (rd_word)
    );

    rstk_alu #(.DATA_W(DATA_W)) u_alu (
        .sel (state_q.op),
        .a   (state_q.opa),
        .b   (state_q.opb),
        .y   (alu_y)
    );

    always_comb begin
        state_d     = state_q;
        state_d.err = 1'b0;
        wr_en       = 1'b0;
        wr_word     = push_data;

        unique case (state_q.st)
            SEQ_IDLE: begin
                if (cmd_valid) begin
                    unique case (cmd_op)
                        CMD_PUSH: begin
                            if (can_push) begin
                                wr_en         = 1'b1;
                                wr_word       = push_data;
                                state_d.sp    = sp_up;
                                state_d.full  = wrap_up;
                                state_d.empty = 1'b0;
                            end else begin
                                state_d.err = 1'b1;
                            end
                        end
                        CMD_POP: begin
                            if (can_pop) begin
                                state_d.dr    = rd_word;
                                state_d.sp    = sp_dn;
                                state_d.empty = zero_dn;
                                state_d.full  = 1'b0;
                            end else begin
                                state_d.err = 1'b1;
                            end
                        end
                        CMD_OR, CMD_AND, CMD_XOR: begin
                            if (has_two) begin
                                state_d.opa   = rd_word;
                                state_d.sp    = sp_dn;
                                state_d.empty = zero_dn;
                                state_d.full  = 1'b0;
                                state_d.st    = SEQ_POP2;
                                if (cmd_op == CMD_AND) begin
                                    state_d.op = LOP_AND;
                                end else if (cmd_op == CMD_XOR) begin
                                    state_d.op = LOP_XOR;
                                end else begin
                                    state_d.op = LOP_OR;
                                end
                            end else begin
                                state_d.err = 1'b1;
                            end
                        end
                        default: begin
                            state_d.err = 1'b1;
                        end
                    endcase
                end
            end
            SEQ_POP2: begin
                state_d.err   = cmd_valid;
                state_d.opb   = rd_word;
                state_d.sp    = sp_dn;
                state_d.empty = zero_dn;
                state_d.full  = 1'b0;
                state_d.st    = SEQ_CALC;
            end
            SEQ_CALC: begin
                state_d.err = cmd_valid;
                state_d.res = alu_y;
                state_d.st  = SEQ_PUSH;
            end
            SEQ_PUSH: begin
                state_d.err   = cmd_valid;
                wr_en         = 1'b1;
                wr_word       = state_q.res;
                state_d.sp    = sp_up;
                state_d.full  = wrap_up;
                state_d.empty = 1'b0;
                state_d.st    = SEQ_IDLE;
            end
            default: begin
                state_d.st = SEQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RST_VAL;
        end else begin
            state_q <= state_d;
        end
    end

    assign pop_data = state_q.dr;
    assign stk_ptr  = state_q.sp;
    assign full     = state_q.full;
    assign empty    = state_q.empty;
    assign busy     = (state_q.st != SEQ_IDLE);
    assign err      = state_q.err;

endmodule

// File: rtl/rstk_chk.sv
module rstk_chk
    import rstk_pkg::*;
#(
    parameter int PTR_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [2:0]       cmd_op,
    input logic [PTR_W-1:0] stk_ptr,
    input logic             full,
    input logic             empty,
    input logic             busy,
    input logic             err
);
    logic idle_cmd;
    logic is_bin;
    logic is_bad;

    assign idle_cmd = cmd_valid & ~busy;
    assign is_bin   = (cmd_op == CMD_OR) | (cmd_op == CMD_AND) | (cmd_op == CMD_XOR);
    assign is_bad   = (cmd_op == 3'b000) | (cmd_op == 3'b110) | (cmd_op == 3'b111);

    assert_push_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        idle_cmd && cmd_op == CMD_PUSH && !full
        |=> stk_ptr == PTR_W'($past(stk_ptr) + PTR_W'(1)) && !empty);

    assert_pop_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        idle_cmd && cmd_op == CMD_POP && !empty
        |=> stk_ptr == PTR_W'($past(stk_ptr) - PTR_W'(1)) && !full);

    assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    assert_zero_ptr_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stk_ptr == '0 |-> (full || empty));

    assert_push_full_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
        idle_cmd && cmd_op == CMD_POP - 3'd1 && full
        |=> err && full && $stable(stk_ptr));

    assert_pop_empty_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
        idle_cmd && cmd_op == CMD_POP && empty
        |=> err && empty && $stable(stk_ptr));

    assert_bin_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        idle_cmd && is_bin && (full || (!empty && stk_ptr >= PTR_W'(2)))
        |=> busy && !err);

    assert_bin_short_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
        idle_cmd && is_bin && !full && (empty || stk_ptr < PTR_W'(2))
        |=> err && !busy && $stable(stk_ptr));

    assert_busy_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && busy |=> err);

    assert_bad_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        idle_cmd && is_bad |=> err && $stable(stk_ptr) && $stable(full) && $stable(empty));

    assert_quiet_no_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !err);

endmodule

bind rstk_top rstk_chk #(.PTR_W(PTR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .stk_ptr   (stk_ptr),
    .full      (full),
    .empty     (empty),
    .busy      (busy),
    .err       (err)
);

// File: tb/tb_rstk_top.sv
`timescale 1ns/1ps
module tb_rstk_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'b000;
    logic [7:0] push_data = 8'h00;
    logic [7:0] pop_data;
    logic [5:0] stk_ptr;
    logic       full, empty, busy, err;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [7:0] stk [64];
    int cnt = 0;
    logic [7:0] last_pop = 8'h00;

    always #2.5 clk = ~clk;

    rstk_top dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .push_data(push_data), .pop_data(pop_data), .stk_ptr(stk_ptr),
        .full(full), .empty(empty), .busy(busy), .err(err)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        chk({req, " ptr"}, int'(stk_ptr), cnt % 64);
        chk({req, " full"}, int'(full), (cnt == 64) ? 1 : 0);
        chk({req, " empty"}, int'(empty), (cnt == 0) ? 1 : 0);
    endtask

    task automatic issue(input logic [2:0] c, input logic [7:0] d);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = c;
        push_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    function automatic logic [7:0] calc(input logic [2:0] c, input logic [7:0] a, input logic [7:0] b);
        if (c == 3'b011) return a | b;
        if (c == 3'b100) return a & b;
        return a ^ b;
    endfunction

    task automatic do_push(input logic [7:0] d);
        issue(3'b001, d);
        if (cnt < 64) begin
            stk[cnt] = d;
            cnt++;
            chk("R2 err", int'(err), 0);
            check_state("R2");
        end else begin
            chk("R5 err", int'(err), 1);
            check_state("R5");
            @(negedge clk);
            chk("R5 err one cycle", int'(err), 0);
        end
    endtask

    task automatic do_pop();
        issue(3'b010, 8'h00);
        if (cnt > 0) begin
            cnt--;
            last_pop = stk[cnt];
            chk("R3 data", int'(pop_data), int'(stk[cnt]));
            chk("R3 err", int'(err), 0);
            check_state("R3");
        end else begin
            chk("R6 err", int'(err), 1);
            chk("R6 data kept", int'(pop_data), int'(last_pop));
            check_state("R6");
        end
    endtask

    task automatic do_bin(input logic [2:0] c);
        logic [7:0] r;
        issue(c, 8'h00);
        if (cnt >= 2) begin
            chk("R9 busy 1", int'(busy), 1);
            chk("R7 err", int'(err), 0);
            @(negedge clk);
            chk("R9 busy 2", int'(busy), 1);
            @(negedge clk);
            chk("R9 busy 3", int'(busy), 1);
            @(negedge clk);
            chk("R9 busy end", int'(busy), 0);
            r = calc(c, stk[cnt-1], stk[cnt-2]);
            cnt--;
            stk[cnt-1] = r;
            check_state("R7");
        end else begin
            chk("R8 err", int'(err), 1);
            chk("R8 busy", int'(busy), 0);
            check_state("R8");
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 ptr", int'(stk_ptr), 0);
        chk("R1 empty", int'(empty), 1);
        chk("R1 full", int'(full), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 err", int'(err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_state("R1");
        chk("R1 err after", int'(err), 0);

        // R10: undefined codes and an idle command line
        foreach (stk[i]) stk[i] = 8'h00;
        for (int k = 0; k < 3; k++) begin
            logic [2:0] c;
            c = (k == 0) ? 3'b000 : (k == 1) ? 3'b110 : 3'b111;
            issue(c, 8'h33);
            chk("R10 err", int'(err), 1);
            check_state("R10");
        end
        @(negedge clk);
        cmd_op = 3'b001;
        push_data = 8'h77;
        @(negedge clk);
        chk("R10 no valid err", int'(err), 0);
        check_state("R10 no valid");

        do_pop();                // R6 on empty
        do_bin(3'b011);          // R8 with zero words
        do_push(8'hA5);
        do_bin(3'b100);          // R8 with one word
        do_pop();
        do_pop();

        // R4: fill to wrap
        for (int i = 0; i < 64; i++) do_push(8'((i * 37 + 11) & 255));
        chk("R4 full", int'(full), 1);
        do_push(8'hEE);          // R5
        do_bin(3'b011);          // R7 at full
        for (int i = 0; i < 63; i++) do_pop();
        do_pop();                // R6

        // R7: operand sweep for each logical operation
        for (int c = 3; c <= 5; c++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    do_push(8'((a * 17) & 255));
                    do_push(8'((b * 29 + 3) & 255));
                    do_bin(3'(c));
                    do_pop();
                end
            end
        end

        // R7: deeper words untouched
        do_push(8'h11);
        do_push(8'hF0);
        do_push(8'h0F);
        do_bin(3'b101);
        do_pop();
        do_pop();

        // R9: command during busy is refused
        do_push(8'h3C);
        do_push(8'hC3);
        do_push(8'h5A);
        issue(3'b100, 8'h00);
        cmd_valid = 1'b1;
        cmd_op    = 3'b001;
        push_data = 8'hEE;
        @(negedge clk);
        chk("R9 busy refuse err", int'(err), 1);
        cmd_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R9 busy end", int'(busy), 0);
        stk[1] = calc(3'b100, stk[2], stk[1]);
        cnt = 2;
        check_state("R9");
        do_pop();
        do_pop();
        do_pop();

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule